// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

The block is a circular buffer of result slots that sits between out-of-order completion and architectural update. Each instruction reserves a slot when it issues and gets that slot's index back. Functional units later post a value, an exception flag with a cause code and, for branches, a misprediction flag into the slot. Waiting instructions read operands straight from slots through a lookup port. Only the oldest slot may retire, and only once its result has arrived. Retiring produces the register-file or memory write. Completing a slot never updates any state.

Two events discard speculative work. The first is an early squash input that names a branch slot: everything younger than that branch is dropped. The second happens at retirement. A mispredicted branch, or an instruction that raised an exception, empties the buffer when it reaches the head and raises a redirect or exception indication. Exceptions are therefore precise, because nothing older is lost and nothing younger has written.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `commit_rf_we`, `commit_mem_we`, `redirect` and `exc_valid` are 0.
- R2: An accepted allocation returns the current tail index on `alloc_idx` in the same cycle. The next index is one higher, modulo DEPTH (7 wraps to 0 with DEPTH=8).
- R3: After DEPTH allocations with no retirement, `alloc_ready` is 0 and a request with `alloc_valid` set is ignored, leaving `alloc_idx` unchanged. One retirement makes `alloc_ready` 1 again.
- R4: Completion writes nothing. The head slot retires only while its result is present, at most one slot per cycle, in allocation order. Younger slots that are already complete retire on consecutive cycles.
- R5: The kind code chosen at allocation sets the retirement action. Code 0 (register) drives `commit_rf_we`. Code 1 (store) drives `commit_mem_we`. Code 2 (branch) drives no write. The slot's destination and value appear on `commit_dest` and `commit_value`.
- R6: `look_ready` and `look_value` show the completion state and value of the slot selected by `look_idx`, in the same cycle.
- R7: A head branch completed with the misprediction flag raises `redirect` for one cycle and writes nothing. All younger slots are discarded, even completed ones. The next allocation index is the branch index plus one.
- R8: A head slot completed with the exception flag raises `exc_valid` with its cause on `exc_cause` and writes nothing. All slots are discarded, and the next allocation index is that slot's index plus one.
- R9: While `squash` is set, slots younger than `squash_idx` are discarded and the next allocation index becomes `squash_idx` plus one. The slots from the head up to `squash_idx` still retire normally.
- R10: `alloc_ready` is 0 in any cycle where `squash` is set or a retirement-time flush (R7, R8) occurs, so an allocation in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to reserve a slot |
| alloc_kind | input | 2 | Kind code: 0 register, 1 store, 2 branch |
| alloc_dest | input | DEST_W | Destination register or store tag |
| alloc_ready | output | 1 | A slot can be reserved this cycle |
| alloc_idx | output | IDX_W | Index of the slot being reserved |
| done_valid | input | 1 | Completion write strobe |
| done_idx | input | IDX_W | Slot being completed |
| done_value | input | DATA_W | Result value |
| done_exc | input | 1 | Instruction raised an exception |
| done_cause | input | CAUSE_W | Exception cause |
| done_mispred | input | 1 | Branch was mispredicted |
| look_idx | input | IDX_W | Slot read by the operand lookup |
| look_ready | output | 1 | Looked-up slot holds a result |
| look_value | output | DATA_W | Looked-up slot value |
| squash | input | 1 | Early discard of slots younger than squash_idx |
| squash_idx | input | IDX_W | Branch slot that bounds the discard |
| commit_rf_we | output | 1 | Register-file write on retirement |
| commit_mem_we | output | 1 | Memory write on retirement |
| commit_dest | output | DEST_W | Destination of the retiring slot |
| commit_value | output | DATA_W | Value of the retiring slot |
| redirect | output | 1 | Mispredicted branch retiring |
| exc_valid | output | 1 | Excepting instruction reached retirement |
| exc_cause | output | CAUSE_W | Cause of that exception |

## Verification
Some rules are checked by the bound checker on every cycle. The occupancy never exceeds the depth, and a full buffer refuses allocation. Accepted allocations step the tail by one, and each retiring write steps the head by one. At most one retirement action is active at a time, and an exception never coincides with a write. A retirement-time flush leaves the buffer empty, a squash moves the tail to just past the named slot, and allocation is blocked while a squash is asserted. Other properties need the bench's directed scenarios. These are retirement in allocation order with specific values and destinations, the write kind chosen by each kind code, lookup contents, and the fact that discarded slots with a result already present never retire. Wrap-around of the indices is also shown only by the scenarios.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr.sv
// Head/tail/occupancy control for the circular slot array (DEPTH must be a power of two).
module rob_ptr #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             commit_fire,
  input  logic             flush_all,
  input  logic             squash,
  input  logic [IDX_W-1:0] squash_idx,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] cnt
);
  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, span;
  logic             ptr_en;

  assign ptr_en = alloc_fire | commit_fire | flush_all | squash;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    span   = '0;
    if (flush_all) begin
      head_d = head_q + IDX_W'(1);
      tail_d = head_d;
      cnt_d  = '0;
    end else if (squash) begin
      // Slots from head through squash_idx survive.
      span   = CNT_W'(IDX_W'(squash_idx - head_q)) + CNT_W'(1);
      head_d = head_q + IDX_W'(commit_fire);
      tail_d = squash_idx + IDX_W'(1);
      cnt_d  = span - CNT_W'(commit_fire);
    end else begin
      head_d = head_q + IDX_W'(commit_fire);
      tail_d = tail_q + IDX_W'(alloc_fire);
      cnt_d  = cnt_q + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/rob_store.sv
// Slot storage: written at allocation and at completion, read at head and by lookup.
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 32,
  parameter int DEST_W  = 5,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_fire,
  input  logic [IDX_W-1:0]   tail,
  input  rob_kind_e          alloc_kind,
  input  logic [DEST_W-1:0]  alloc_dest,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic [DATA_W-1:0]  done_value,
  input  logic               done_exc,
  input  logic [CAUSE_W-1:0] done_cause,
  input  logic               done_mispred,
  input  logic [IDX_W-1:0]   head,
  output rob_kind_e          h_kind,
  output logic [DEST_W-1:0]  h_dest,
  output logic [DATA_W-1:0]  h_value,
  output logic               h_ready,
  output logic               h_exc,
  output logic [CAUSE_W-1:0] h_cause,
  output logic               h_mispred,
  input  logic [IDX_W-1:0]   look_idx,
  output logic               look_ready,
  output logic [DATA_W-1:0]  look_value
);
  rob_kind_e          kind_q  [DEPTH];
  logic [DEST_W-1:0]  dest_q  [DEPTH];
  logic [DATA_W-1:0]  value_q [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];
  logic [DEPTH-1:0]   ready_q, exc_q, mis_q;
  logic [DEPTH-1:0]   alloc_hit, done_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign alloc_hit[g] = alloc_fire && (tail == IDX_W'(g));
    assign done_hit[g]  = done_valid && (done_idx == IDX_W'(g)) && !alloc_hit[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_hit[i])     ready_q[i] <= 1'b0;
        else if (done_hit[i]) ready_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_hit[i]) begin
        kind_q[i] <= alloc_kind;
        dest_q[i] <= alloc_dest;
      end
      if (done_hit[i]) begin
        value_q[i] <= done_value;
        exc_q[i]   <= done_exc;
        cause_q[i] <= done_cause;
        mis_q[i]   <= done_mispred;
      end
    end
  end

  assign h_kind     = kind_q[head];
  assign h_dest     = dest_q[head];
  assign h_value    = value_q[head];
  assign h_ready    = ready_q[head];
  assign h_exc      = exc_q[head];
  assign h_cause    = cause_q[head];
  assign h_mispred  = mis_q[head];
  assign look_ready = ready_q[look_idx];
  assign look_value = value_q[look_idx];
endmodule

// File: rtl/rob_commit.sv
// Decodes the head slot into retirement actions.
module rob_commit
  import rob_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               live,
  input  rob_kind_e          h_kind,
  input  logic               h_ready,
  input  logic               h_exc,
  input  logic [CAUSE_W-1:0] h_cause,
  input  logic               h_mispred,
  output logic               commit_fire,
  output logic               flush_all,
  output logic               rf_we,
  output logic               mem_we,
  output logic               redirect,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause
);
  logic branch_bad;

  always_comb begin
    commit_fire = live && h_ready;
    branch_bad  = (h_kind == KIND_BRANCH) && h_mispred;
    exc_valid   = commit_fire && h_exc;
    redirect    = commit_fire && !h_exc && branch_bad;
    rf_we       = commit_fire && !h_exc && (h_kind == KIND_REG);
    mem_we      = commit_fire && !h_exc && (h_kind == KIND_STORE);
    flush_all   = exc_valid || redirect;
    exc_cause   = exc_valid ? h_cause : '0;
  end
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 32,
  parameter int DEST_W  = 5,
  parameter int CAUSE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [1:0]         alloc_kind,
  input  logic [DEST_W-1:0]  alloc_dest,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_idx,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_idx,
  input  logic [DATA_W-1:0]  done_value,
  input  logic               done_exc,
  input  logic [CAUSE_W-1:0] done_cause,
  input  logic               done_mispred,
  input  logic [IDX_W-1:0]   look_idx,
  output logic               look_ready,
  output logic [DATA_W-1:0]  look_value,
  input  logic               squash,
  input  logic [IDX_W-1:0]   squash_idx,
  output logic               commit_rf_we,
  output logic               commit_mem_we,
  output logic [DEST_W-1:0]  commit_dest,
  output logic [DATA_W-1:0]  commit_value,
  output logic               redirect,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause
);
  logic [IDX_W-1:0]   head_idx, tail_idx;
  logic [CNT_W-1:0]   cnt;
  logic               alloc_fire, commit_fire, flush_all;
  rob_kind_e          h_kind;
  logic               h_ready, h_exc, h_mispred;
  logic [CAUSE_W-1:0] h_cause;

  assign alloc_ready = (cnt != CNT_W'(DEPTH)) && !squash && !flush_all;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_idx;

  rob_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_ptr (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .commit_fire(commit_fire), .flush_all(flush_all),
    .squash(squash), .squash_idx(squash_idx),
    .head(head_idx), .tail(tail_idx), .cnt(cnt)
  );

  rob_store #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .DEST_W(DEST_W), .CAUSE_W(CAUSE_W)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .tail(tail_idx),
    .alloc_kind(rob_kind_e'(alloc_kind)), .alloc_dest(alloc_dest),
    .done_valid(done_valid), .done_idx(done_idx), .done_value(done_value),
    .done_exc(done_exc), .done_cause(done_cause), .done_mispred(done_mispred),
    .head(head_idx),
    .h_kind(h_kind), .h_dest(commit_dest), .h_value(commit_value), .h_ready(h_ready),
    .h_exc(h_exc), .h_cause(h_cause), .h_mispred(h_mispred),
    .look_idx(look_idx), .look_ready(look_ready), .look_value(look_value)
  );

  rob_commit #(.CAUSE_W(CAUSE_W)) i_commit (
    .live(cnt != '0), .h_kind(h_kind), .h_ready(h_ready), .h_exc(h_exc),
    .h_cause(h_cause), .h_mispred(h_mispred),
    .commit_fire(commit_fire), .flush_all(flush_all),
    .rf_we(commit_rf_we), .mem_we(commit_mem_we),
    .redirect(redirect), .exc_valid(exc_valid), .exc_cause(exc_cause)
  );
endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             squash,
  input logic [IDX_W-1:0] squash_idx,
  input logic             commit_rf_we,
  input logic             commit_mem_we,
  input logic             redirect,
  input logic             exc_valid,
  input logic [IDX_W-1:0] head_idx,
  input logic [CNT_W-1:0] cnt
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R3
  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH)) |-> !alloc_ready); // R3
  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)); // R2
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_rf_we || commit_mem_we) |=> head_idx == IDX_W'($past(head_idx) + 1'b1)); // R4
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({commit_rf_we, commit_mem_we, redirect, exc_valid}) <= 1); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> cnt == '0); // R7
  AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> cnt == '0); // R8
  AST_SQUASH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && !redirect && !exc_valid) |=> alloc_idx == IDX_W'($past(squash_idx) + 1'b1)); // R9
  AST_SQUASH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> !alloc_ready); // R10
endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_idx(alloc_idx), .squash(squash), .squash_idx(squash_idx),
  .commit_rf_we(commit_rf_we), .commit_mem_we(commit_mem_we),
  .redirect(redirect), .exc_valid(exc_valid), .head_idx(head_idx), .cnt(cnt)
);

// File: tb/test_reorder_buf.sv
`timescale 1ns/1ps
module test_reorder_buf;
  localparam int DEPTH = 8, DATA_W = 32, DEST_W = 5, CAUSE_W = 4, IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid, alloc_ready;
  logic [1:0] alloc_kind;
  logic [DEST_W-1:0] alloc_dest, commit_dest;
  logic [IDX_W-1:0] alloc_idx, done_idx, look_idx, squash_idx;
  logic done_valid, done_exc, done_mispred, look_ready, squash;
  logic [DATA_W-1:0] done_value, look_value, commit_value;
  logic [CAUSE_W-1:0] done_cause, exc_cause;
  logic commit_rf_we, commit_mem_we, redirect, exc_valid;

  int checks = 0, errors = 0, exp_tail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .CAUSE_W(CAUSE_W)) i_reorder_buf (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .done_valid(done_valid), .done_idx(done_idx), .done_value(done_value),
    .done_exc(done_exc), .done_cause(done_cause), .done_mispred(done_mispred),
    .look_idx(look_idx), .look_ready(look_ready), .look_value(look_value),
    .squash(squash), .squash_idx(squash_idx),
    .commit_rf_we(commit_rf_we), .commit_mem_we(commit_mem_we),
    .commit_dest(commit_dest), .commit_value(commit_value),
    .redirect(redirect), .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_kind = 0; alloc_dest = 0;
    done_valid = 0; done_idx = 0; done_value = 0; done_exc = 0; done_cause = 0; done_mispred = 0;
    look_idx = 0; squash = 0; squash_idx = 0;
  endtask

  task automatic step();
    @(posedge clk); #2; idle(); #2;
  endtask

  task automatic expect_commit(input string req, input bit rf, input bit mem,
                               input int dest, input int val);
    chk(commit_rf_we == rf, req, "rf_we", commit_rf_we, rf);
    chk(commit_mem_we == mem, req, "mem_we", commit_mem_we, mem);
    if (rf || mem) begin
      chk(commit_dest == DEST_W'(dest), req, "dest", commit_dest, dest);
      chk(commit_value == DATA_W'(val), req, "value", commit_value, val);
    end
  endtask

  task automatic alloc(input int kind, input int dest, output int idx);
    alloc_valid = 1; alloc_kind = 2'(kind); alloc_dest = DEST_W'(dest); #1;
    chk(alloc_ready == 1, "R2", "alloc_ready", alloc_ready, 1);
    chk(alloc_idx == IDX_W'(exp_tail), "R2", "alloc_idx", alloc_idx, exp_tail);
    idx = int'(alloc_idx);
    step();
    exp_tail = (exp_tail + 1) % DEPTH;
  endtask

  task automatic complete(input int idx, input int val, input bit exc,
                          input int cause, input bit mp);
    done_valid = 1; done_idx = IDX_W'(idx); done_value = DATA_W'(val);
    done_exc = exc; done_cause = CAUSE_W'(cause); done_mispred = mp;
    step();
  endtask

  task automatic t_reset();
    chk(alloc_ready == 1, "R1", "alloc_ready", alloc_ready, 1);
    chk(alloc_idx == 0, "R1", "alloc_idx", alloc_idx, 0);
    chk(!commit_rf_we && !commit_mem_we && !redirect && !exc_valid, "R1", "commit outputs",
        {commit_rf_we, commit_mem_we, redirect, exc_valid}, 0);
  endtask

  task automatic t_in_order();
    int a, b, c;
    alloc(0, 1, a); alloc(0, 2, b); alloc(0, 3, c);
    expect_commit("R4", 0, 0, 0, 0);
    complete(c, 'h33, 0, 0, 0);
    expect_commit("R4", 0, 0, 0, 0);        // youngest ready, head not ready
    look_idx = IDX_W'(c); #1;
    chk(look_ready == 1, "R6", "look_ready", look_ready, 1);
    chk(look_value == 'h33, "R6", "look_value", look_value, 'h33);
    look_idx = IDX_W'(a); #1;
    chk(look_ready == 0, "R6", "look_ready pending", look_ready, 0);
    complete(a, 'h11, 0, 0, 0);
    expect_commit("R5", 1, 0, 1, 'h11);
    step();
    expect_commit("R4", 0, 0, 0, 0);
    complete(b, 'h22, 0, 0, 0);
    expect_commit("R4", 1, 0, 2, 'h22);
    step();
    expect_commit("R4", 1, 0, 3, 'h33);
    step();
    expect_commit("R4", 0, 0, 0, 0);
  endtask

  task automatic t_kinds();
    int s, br;
    alloc(1, 7, s); alloc(2, 0, br);
    complete(br, 0, 0, 0, 0);
    expect_commit("R5", 0, 0, 0, 0);
    complete(s, 'h77, 0, 0, 0);
    expect_commit("R5", 0, 1, 7, 'h77);
    step();
    expect_commit("R5", 0, 0, 0, 0);
    chk(redirect == 0, "R5", "good branch redirect", redirect, 0);
    step();
  endtask

  task automatic t_mispredict();
    int br, x, y;
    alloc(2, 0, br); alloc(0, 9, x); alloc(0, 10, y);
    complete(x, 'h99, 0, 0, 0);
    complete(y, 'hAA, 0, 0, 0);
    complete(br, 0, 0, 0, 1);
    chk(redirect == 1, "R7", "redirect", redirect, 1);
    expect_commit("R7", 0, 0, 0, 0);
    chk(alloc_ready == 0, "R10", "alloc_ready at flush", alloc_ready, 0);
    step();
    chk(redirect == 0, "R7", "redirect one cycle", redirect, 0);
    expect_commit("R7", 0, 0, 0, 0);        // completed younger slots discarded
    exp_tail = (br + 1) % DEPTH;
    chk(alloc_idx == IDX_W'(exp_tail), "R7", "alloc_idx after redirect", alloc_idx, exp_tail);
  endtask

  task automatic t_exception();
    int a, b;
    alloc(0, 4, a); alloc(0, 5, b);
    complete(b, 'h55, 0, 0, 0);
    complete(a, 'h44, 1, 5, 0);
    chk(exc_valid == 1, "R8", "exc_valid", exc_valid, 1);
    chk(exc_cause == 5, "R8", "exc_cause", exc_cause, 5);
    expect_commit("R8", 0, 0, 0, 0);
    step();
    chk(exc_valid == 0, "R8", "exc_valid drops", exc_valid, 0);
    expect_commit("R8", 0, 0, 0, 0);
    exp_tail = (a + 1) % DEPTH;
    chk(alloc_idx == IDX_W'(exp_tail), "R8", "alloc_idx after exception", alloc_idx, exp_tail);
  endtask

  task automatic t_squash();
    int i0, i1, i2, i3;
    alloc(0, 11, i0); alloc(0, 12, i1); alloc(0, 13, i2); alloc(0, 14, i3);
    squash = 1; squash_idx = IDX_W'(i1);
    alloc_valid = 1; alloc_kind = 0; alloc_dest = 20; #1;
    chk(alloc_ready == 0, "R10", "alloc_ready during squash", alloc_ready, 0);
    step();
    exp_tail = (i1 + 1) % DEPTH;
    chk(alloc_idx == IDX_W'(exp_tail), "R9", "alloc_idx after squash", alloc_idx, exp_tail);
    complete(i2, 'hC3, 0, 0, 0);
    complete(i3, 'hC4, 0, 0, 0);
    complete(i1, 'hC2, 0, 0, 0);
    expect_commit("R9", 0, 0, 0, 0);
    complete(i0, 'hC1, 0, 0, 0);
    expect_commit("R9", 1, 0, 11, 'hC1);
    step();
    expect_commit("R9", 1, 0, 12, 'hC2);
    step();
    expect_commit("R9", 0, 0, 0, 0);        // discarded slots never retire
  endtask

  task automatic t_full();
    int idx [DEPTH];
    for (int k = 0; k < DEPTH; k++) alloc(0, 16 + k, idx[k]);
    chk(alloc_ready == 0, "R3", "alloc_ready when full", alloc_ready, 0);
    alloc_valid = 1; alloc_kind = 0; alloc_dest = 31;
    step();
    chk(alloc_idx == IDX_W'(exp_tail), "R3", "alloc_idx unchanged", alloc_idx, exp_tail);
    for (int k = 0; k < DEPTH; k++) begin
      complete(idx[k], 'h100 + k, 0, 0, 0);
      expect_commit("R4", 1, 0, 16 + k, 'h100 + k);
      if (k == 1) chk(alloc_ready == 1, "R3", "alloc_ready after retire", alloc_ready, 1);
    end
    step();
    expect_commit("R4", 0, 0, 0, 0);
  endtask

  initial begin
    idle();
    #45 rst_n = 1'b1;
    @(posedge clk); #4;
    t_reset();
    t_in_order();
    t_kinds();
    t_mispredict();
    t_exception();
    t_squash();
    t_full();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule